// File: doc/BRIEF.md
# Key-Protected Debug Erase Controller

This block sits on the debugger side of a device and gives an external debug probe two recovery actions: a full device erase and a system reset request. The probe reaches a small register space over a simple synchronous read/write bus. A command can only be latched after a 32-bit unlock key has been written to the key register. A latched command runs at the moment that key is replaced by any other value. This two-step arm-then-fire sequence makes a stray write unable to wipe the device.

After every reset the port opens for a timed access window. The window is normally `WIN_CYC` clock cycles long. It lasts `WIN_CYC * EXP_MULT` cycles if the expand request input is high while reset is asserted. The low nibble of the lock word decides what happens once the window ends:
- **Unlocked device:** the port closes and core/bus access is granted.
- **Locked device:** the port stays reachable and core/bus access stays blocked.

On an unlocked device, an erase fired inside the window is held back until the window closes. While an erase is pending or running, a status bit reads back busy. When the erase finishes, the block emits a one-cycle strobe asking the lock storage to be rewritten with the unlocked value, so access returns after the next reset.

Top module: `dbg_erase_port`

## Requirements
- R1: After reset release, `port_open` is 1 and `core_access` is 0 for exactly `WIN_CYC` clock edges; the window then closes and stays closed until the next reset.
- R2: If `expand_req` is 1 on the last reset edge, the window lasts `WIN_CYC * EXP_MULT` edges instead.
- R3: With `lock_word[3:0] == 4'hF` (unlocked), after the window `port_open` is 0 and `core_access` is 1. Bus writes then have no effect, and bus reads return 0.
- R4: With any other `lock_word[3:0]` value (locked), `port_open` stays 1 and `core_access` stays 0 after the window ends.
- R5: The read-only identity register at offset 0x0FC reads 0x16E60001. Unmapped offsets read 0.
- R6: The command register (offset 0x000) has two write-one bits: bit 0 requests an erase and bit 1 requests a system reset. Writes to it are ignored unless the key register (offset 0x004) holds 0xCFACC118. Reading the command register returns the latched bits.
- R7: Latched commands fire on the write that changes the key register from 0xCFACC118 to any other value. This clears the latch. `sysreset_req` pulses high for one cycle, the cycle right after that write. Nothing fires before that write.
- R8: A fired erase starts (`erase_req` rises) on the next edge on a locked device. On an unlocked device during the window, it waits and starts one edge after the window has closed.
- R9: The status register (offset 0x008) bit 0 reads 1 from erase acceptance until completion. An erase holds `erase_req` high for at least `ERASE_CYC` cycles and until `erase_done` is seen.
- R10: On erase completion, `erase_req` falls and `unlock_wr` pulses high for exactly one cycle.
- R11: Reserved bits read as zero. For example, writing all ones into the command register reads back only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| expand_req | input | 1 | Sampled during reset; selects the long access window |
| lock_word | input | 32 | Lock word; low nibble 4'hF means unlocked |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| port_open | output | 1 | Port registers reachable |
| core_access | output | 1 | Core and bus access allowed |
| erase_req | output | 1 | Device erase in progress request |
| erase_done | input | 1 | Erase engine reports completion |
| sysreset_req | output | 1 | One-cycle system reset request |
| unlock_wr | output | 1 | One-cycle strobe to rewrite the lock word as unlocked |

## Verification
The bench builds the block with `WIN_CYC = 20`, `EXP_MULT = 5` and `ERASE_CYC = 16`. With these values both window lengths can be measured to the exact edge, and a full erase fits in a few dozen cycles. The small window also lets an erase fired early in the window be seen waiting for the window to close and then running to completion. Locked and unlocked runs come from separate resets, so the closed port and the persistently open port are both exercised.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int DW = 32;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_KEY  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_ID   = 8'hFC;
  localparam logic [DW-1:0] UNLOCK_KEY = 32'hCFACC118;
  localparam logic [DW-1:0] PORT_ID    = 32'h16E60001;
  localparam logic [3:0]    OPEN_NIB   = 4'hF;
  typedef enum logic [1:0] {ER_IDLE = 2'd0, ER_WAIT = 2'd1, ER_RUN = 2'd2} er_state_e;
endpackage

// File: rtl/dbgp_window.sv
module dbgp_window #(
  parameter int WIN_CYC  = 658,
  parameter int EXP_MULT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic expand_req,
  output logic win_open
);
  localparam int LONG_CYC = WIN_CYC * EXP_MULT;
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt;
  logic          exp_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = exp_q ? LONG_M1 : SHORT_M1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      win_open <= 1'b1;
      exp_q    <= expand_req;
    end else if (win_open) begin
      cnt <= cnt + 1'b1;
      if (cnt == lim_m1) win_open <= 1'b0;
    end
  end

  // R1: once closed, the window never reopens without reset
  assert_closed_stays_closed_R1: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> !win_open);
  // R2: the window-length choice is frozen outside reset
  assert_expand_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(exp_q));
  // R1: the counter never passes the selected limit while open
  assert_count_bounded_R1: assert property (@(posedge clk) disable iff (rst)
    win_open |-> (cnt <= lim_m1));
endmodule

// File: rtl/dbgp_cmd.sv
module dbgp_cmd
  import dbgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          wr_key,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_q,
  output logic [1:0]    pend,
  output logic          exec_erase,
  output logic          exec_reset
);
  logic key_ok;
  assign key_ok = (key_q == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q      <= '0;
      pend       <= '0;
      exec_erase <= 1'b0;
      exec_reset <= 1'b0;
    end else begin
      exec_erase <= 1'b0;
      exec_reset <= 1'b0;
      if (wr_cmd && key_ok) pend <= pend | wdata[1:0];
      if (wr_key) begin
        key_q <= wdata;
        if (key_ok && (wdata != UNLOCK_KEY)) begin
          exec_erase <= pend[0];
          exec_reset <= pend[1];
          pend       <= '0;
        end
      end
    end
  end

  // R6: new command bits appear only while the key is armed
  assert_latch_needs_key_R6: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) != 2'b00) |-> $past(key_ok));
  // R7: a fired reset follows an armed key and lasts one cycle
  assert_reset_after_key_R7: assert property (@(posedge clk) disable iff (rst)
    exec_reset |-> ($past(key_ok) && $past(wr_key)));
  assert_reset_single_R7: assert property (@(posedge clk) disable iff (rst)
    exec_reset |=> !exec_reset);
  // R7: firing empties the latch
  assert_fire_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_reset || exec_erase) |-> (pend == 2'b00));
endmodule

// File: rtl/dbgp_erase.sv
module dbgp_erase
  import dbgp_pkg::*;
#(
  parameter int ERASE_CYC = 560000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  input  logic erase_done,
  output logic erase_req,
  output logic busy,
  output logic unlock_wr
);
  localparam int TW = $clog2(ERASE_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(ERASE_CYC - 1);

  er_state_e     state, nxt;
  logic [TW-1:0] tcnt;
  logic          done_seen;
  logic          finish;

  assign finish = (tcnt == T_LAST) && (done_seen || erase_done);

  always_comb begin
    nxt = state;
    unique case (state)
      ER_IDLE: if (start) nxt = hold ? ER_WAIT : ER_RUN;
      ER_WAIT: if (!hold) nxt = ER_RUN;
      ER_RUN:  if (finish) nxt = ER_IDLE;
      default: nxt = ER_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ER_IDLE;
      tcnt      <= '0;
      done_seen <= 1'b0;
      erase_req <= 1'b0;
      busy      <= 1'b0;
      unlock_wr <= 1'b0;
    end else begin
      state     <= nxt;
      erase_req <= (nxt == ER_RUN);
      busy      <= (nxt != ER_IDLE);
      unlock_wr <= (state == ER_RUN) && (nxt == ER_IDLE);
      if (state != ER_RUN) begin
        tcnt      <= '0;
        done_seen <= 1'b0;
      end else begin
        done_seen <= done_seen | erase_done;
        if (tcnt != T_LAST) tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R8: an erase never starts while held by the open window
  assert_no_start_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_req) |-> !$past(hold));
  // R9: status is busy whenever the erase request is active
  assert_busy_covers_req_R9: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> busy);
  // R10: unlock strobe follows a running erase and lasts one cycle
  assert_unlock_after_erase_R10: assert property (@(posedge clk) disable iff (rst)
    unlock_wr |-> ($past(erase_req) && !erase_req));
  assert_unlock_single_R10: assert property (@(posedge clk) disable iff (rst)
    unlock_wr |=> !unlock_wr);
endmodule

// File: rtl/dbg_erase_port.sv
module dbg_erase_port
  import dbgp_pkg::*;
#(
  parameter int WIN_CYC   = 658,
  parameter int EXP_MULT  = 255,
  parameter int ERASE_CYC = 560000,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expand_req,
  input  logic [DW-1:0] lock_word,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          port_open,
  output logic          core_access,
  output logic          erase_req,
  input  logic          erase_done,
  output logic          sysreset_req,
  output logic          unlock_wr
);
  localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_KEY  = AW'(OFS_KEY);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_ID   = AW'(OFS_ID);

  logic          win_open;
  logic [DW-1:0] lock_q;
  logic          locked;
  logic          acc, wr_cmd, wr_key;
  logic [DW-1:0] key_q;
  logic [1:0]    pend;
  logic          exec_erase;
  logic          erase_busy;

  always_ff @(posedge clk) lock_q <= lock_word;

  assign locked      = (lock_q[3:0] != OPEN_NIB);
  assign port_open   = win_open | locked;
  assign core_access = ~win_open & ~locked;

  assign acc    = bus_sel & port_open;
  assign wr_cmd = acc & bus_we & (bus_addr == A_CMD);
  assign wr_key = acc & bus_we & (bus_addr == A_KEY);

  dbgp_window #(.WIN_CYC(WIN_CYC), .EXP_MULT(EXP_MULT)) u_win (
    .clk(clk), .rst(rst), .expand_req(expand_req), .win_open(win_open));

  dbgp_cmd u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_key(wr_key), .wdata(bus_wdata),
    .key_q(key_q), .pend(pend), .exec_erase(exec_erase), .exec_reset(sysreset_req));

  dbgp_erase #(.ERASE_CYC(ERASE_CYC)) u_er (
    .clk(clk), .rst(rst), .start(exec_erase), .hold(win_open & ~locked),
    .erase_done(erase_done), .erase_req(erase_req), .busy(erase_busy),
    .unlock_wr(unlock_wr));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (acc && !bus_we) begin
      if (bus_addr == A_CMD)       bus_rdata <= {30'd0, pend};
      else if (bus_addr == A_KEY)  bus_rdata <= key_q;
      else if (bus_addr == A_STAT) bus_rdata <= {31'd0, erase_busy};
      else if (bus_addr == A_ID)   bus_rdata <= PORT_ID;
      else                         bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

  // R3: any access while the port is closed returns zero data
  assert_closed_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !port_open) |=> (bus_rdata == '0));
  // R3: a closed port never fires a reset request
  assert_closed_no_fire_R3: assert property (@(posedge clk) disable iff (rst)
    (!port_open && !$past(port_open)) |-> !sysreset_req);
endmodule

// File: tb/sim_dbg_erase_port.sv
module sim_dbg_erase_port;
  localparam int CLK_PER = 10;
  localparam int WIN = 20;
  localparam int EXP = 5;
  localparam int ERC = 16;
  localparam logic [31:0] KEY = 32'hCFACC118;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        expand_req = 1'b0;
  logic [31:0] lock_word = 32'h0000000F;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        port_open, core_access, erase_req, sysreset_req, unlock_wr;
  logic        erase_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dbg_erase_port #(.WIN_CYC(WIN), .EXP_MULT(EXP), .ERASE_CYC(ERC), .AW(8)) u0 (
    .clk(clk), .rst(rst), .expand_req(expand_req), .lock_word(lock_word),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .port_open(port_open), .core_access(core_access),
    .erase_req(erase_req), .erase_done(erase_done), .sysreset_req(sysreset_req),
    .unlock_wr(unlock_wr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic do_reset(input logic [3:0] nib, input logic ex);
    @(negedge clk);
    rst = 1'b1; lock_word = {28'h0, nib}; expand_req = ex;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; expand_req = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    eq("R1 reset port_open", port_open, 1);
    eq("R1 reset core_access", core_access, 0);
    eq("R9 reset erase_req", erase_req, 0);
    eq("R7 reset sysreset_req", sysreset_req, 0);
    eq("R10 reset unlock_wr", unlock_wr, 0);
    eq("R5 reset rdata", bus_rdata, 0);
  endtask

  task automatic t_window_normal();
    do_reset(4'hF, 1'b0);
    repeat (WIN-1) @(posedge clk);
    @(negedge clk);
    eq("R1 open at last window cycle", port_open, 1);
    eq("R1 core blocked in window", core_access, 0);
    step();
    eq("R1 closed after WIN edges", port_open, 0);
    eq("R3 core granted unlocked", core_access, 1);
  endtask

  task automatic t_closed_ignored();
    logic [31:0] d;
    bus_rd(8'hFC, d);
    eq("R3 closed read is zero", d, 0);
    bus_wr(8'h04, KEY);
    bus_wr(8'h00, 32'h3);
    bus_wr(8'h04, 32'h0);
    eq("R3 closed writes do not fire", sysreset_req, 0);
    step();
    eq("R3 closed writes no erase", erase_req, 0);
  endtask

  task automatic t_window_expand();
    do_reset(4'hF, 1'b1);
    repeat (WIN) @(posedge clk);
    @(negedge clk);
    eq("R2 still open past short window", port_open, 1);
    repeat (WIN*EXP - WIN - 1) @(posedge clk);
    @(negedge clk);
    eq("R2 open at last long cycle", port_open, 1);
    step();
    eq("R2 closed after long window", port_open, 0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    do_reset(4'h3, 1'b0);
    repeat (3*WIN) @(posedge clk);
    @(negedge clk);
    eq("R4 locked port stays open", port_open, 1);
    eq("R4 locked core stays blocked", core_access, 0);
    bus_rd(8'hFC, d);
    eq("R5 identity value", d, 32'h16E60001);
    bus_rd(8'h10, d);
    eq("R5 unmapped reads zero", d, 0);
    bus_rd(8'h08, d);
    eq("R9 idle status", d, 0);
  endtask

  task automatic t_cmd_gate();
    logic [31:0] d;
    bus_wr(8'h00, 32'h3);
    bus_rd(8'h00, d);
    eq("R6 command ignored without key", d, 0);
    bus_wr(8'h04, KEY);
    bus_wr(8'h00, 32'hFFFF_FFFE);
    bus_rd(8'h00, d);
    eq("R11 reserved bits read zero", d, 32'h2);
    eq("R7 no fire before key change", sysreset_req, 0);
    bus_wr(8'h04, 32'h0);
    eq("R7 reset pulse after key cleared", sysreset_req, 1);
    step();
    eq("R7 reset pulse single cycle", sysreset_req, 0);
    eq("R7 erase not latched", erase_req, 0);
    bus_rd(8'h00, d);
    eq("R7 latch cleared by firing", d, 0);
  endtask

  task automatic t_erase_locked();
    logic [31:0] d;
    bus_wr(8'h04, KEY);
    bus_wr(8'h00, 32'h1);
    bus_wr(8'h04, 32'h12345678);
    eq("R8 erase not yet started", erase_req, 0);
    step();
    eq("R8 locked erase starts next edge", erase_req, 1);
    bus_rd(8'h08, d);
    eq("R9 status busy during erase", d, 1);
    repeat (ERC + 4) @(posedge clk);
    @(negedge clk);
    eq("R9 erase waits for done", erase_req, 1);
    erase_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    erase_done = 1'b0;
    eq("R10 erase_req falls on done", erase_req, 0);
    eq("R10 unlock strobe", unlock_wr, 1);
    step();
    eq("R10 unlock strobe single", unlock_wr, 0);
    bus_rd(8'h08, d);
    eq("R9 status idle after erase", d, 0);
  endtask

  task automatic t_erase_deferred();
    logic [31:0] d;
    do_reset(4'hF, 1'b0);
    bus_wr(8'h04, KEY);
    bus_wr(8'h00, 32'h1);
    bus_wr(8'h04, 32'h0);
    step();
    eq("R8 erase held in window", erase_req, 0);
    bus_rd(8'h08, d);
    eq("R9 status busy while held", d, 1);
    while (port_open) @(negedge clk);
    eq("R8 not started at close edge", erase_req, 0);
    erase_done = 1'b1;
    step();
    eq("R8 erase starts after close", erase_req, 1);
    repeat (ERC-1) @(posedge clk);
    @(negedge clk);
    eq("R9 minimum erase length", erase_req, 1);
    step();
    eq("R9 erase ends after ERASE_CYC", erase_req, 0);
    eq("R10 unlock strobe deferred case", unlock_wr, 1);
    erase_done = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_window_normal();
    t_closed_ignored();
    t_window_expand();
    t_locked();
    t_cmd_gate();
    t_erase_locked();
    t_erase_deferred();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule